// File: doc/BRIEF.md
# Multi-Key Combination Reset Detector

This block watches a small group of active-low key inputs. It raises a reset request when every key in a group chosen by software is held pressed at the same time. The group is set by a 2-bit configuration field, written through a single-cycle write port. A code of k (where k is not zero) selects keys 0 through k. A code of zero turns the function off.

The field clears to zero on power-on reset. Software must therefore enable the detector before it can act, so it can never serve as a power-on reset source.

The raw key pins pass through a synchronizer. The combined all-pressed condition must then hold for `HOLD_CYCLES` consecutive clocks, which rejects contact bounce and glitches. When the hold count is reached, the block does two things on the same edge:
- it emits a request pulse exactly `PULSE_CYCLES` clocks wide;
- it clears the configuration field, in the same way that the chip reset would.

Because the field is cleared, keys that are still held cannot raise a second request until software writes the field again.

Top module: `kbd_combo_rst`

## Requirements
- R1: With configuration code 3, a request is raised only when keys 0, 1, 2 and 3 are all pressed together. Key i is `key_n[i]`, and a 0 means pressed.
- R2: With code 2, keys 0 to 2 must all be pressed. Key 3 is ignored whatever its level.
- R3: With code 1, keys 0 and 1 must both be pressed. Keys 2 and 3 are ignored whatever their level.
- R4: Code 0 disables the detector, and 0 is the value after power-on reset. While `por_n` is low, `rst_req` is 0. With no configuration write after reset, pressing all keys raises no request.
- R5: The keys pass through `SYNC_STAGES` (2) synchronizing flops. If the selected keys are pressed continuously from just before clock edge 1, `rst_req` is first high after edge `HOLD_CYCLES+2`. Fewer than `HOLD_CYCLES` cycles of the synchronized all-pressed condition raise no request.
- R6: Any cycle in which a selected key is released restarts the hold count. Two presses of `HOLD_CYCLES-1` cycles each, separated by one release cycle, raise no request.
- R7: Each request stays high for exactly `PULSE_CYCLES` consecutive clocks.
- R8: The configuration field is cleared on the edge where the request starts. Keys held afterwards raise no further request until the field is written again. A new write with the keys still held raises one new request. When a fire and a write happen in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_we | input | 1 | Write strobe for the key-group field |
| cfg_wdata | input | CODE_W (2) | New key-group code |
| key_n | input | NUM_KEYS (4) | Raw key pins, active low |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench builds the block with `HOLD_CYCLES` = 4 and `PULSE_CYCLES` = 3, keeping `NUM_KEYS` = 4 and `SYNC_STAGES` = 2. This makes the exact rise edge (edge 6) and the pulse width short enough to sample precisely. It also puts the hold boundary within reach: 4 cycles fire and 3 do not, and a 3-1-3 press pattern tests the count restart. With every key-group code reachable, each code can be paired with key patterns in which an unselected key is released, and the clear-on-fire behaviour can be exercised with the keys held for many cycles afterwards.

// File: rtl/kbd_combo_rst_pkg.sv
package kbd_combo_rst_pkg;

   // State of the request pulse generator
   typedef enum logic [0:0] {
      PLS_IDLE   = 1'b0,
      PLS_ACTIVE = 1'b1
   } pls_state_e;

   // Width of a down/up counter able to hold the value n
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/kbd_combo_rst_sync.sv
module kbd_combo_rst_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   initial begin
      if (STAGES < 2) $error("kbd_combo_rst_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("kbd_combo_rst_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[0] <= '1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[s] <= '1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/kbd_combo_rst_cfg.sv
module kbd_combo_rst_cfg #(
   parameter int unsigned CODE_W = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              clr,
   output logic [CODE_W-1:0] code
);

   initial begin
      if (CODE_W < 1) $error("kbd_combo_rst_cfg: CODE_W must be at least 1");
   end

   // Clear from a fired request takes priority over a software write
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     code <= '0;
      else if (clr)   code <= '0;
      else if (wr_en) code <= wr_data;
   end

endmodule

// File: rtl/kbd_combo_rst_detect.sv
module kbd_combo_rst_detect #(
   parameter int unsigned NUM_KEYS    = 4,
   parameter int unsigned CODE_W      = 2,
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic [CODE_W-1:0]   code,
   input  logic [NUM_KEYS-1:0] keys_s_n,
   input  logic                block,
   output logic                fire
);

   import kbd_combo_rst_pkg::*;

   localparam int unsigned HOLD_W = cnt_width(HOLD_CYCLES);
   localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

   initial begin
      if (HOLD_CYCLES < 1) $error("kbd_combo_rst_detect: HOLD_CYCLES must be at least 1");
      if (NUM_KEYS != (1 << CODE_W)) $error("kbd_combo_rst_detect: NUM_KEYS must equal 2**CODE_W");
   end

   // Selection mask: code k (nonzero) picks keys 0..k
   logic [NUM_KEYS-1:0] sel;
   genvar i;
   generate
      for (i = 0; i < NUM_KEYS; i++) begin : g_sel
         assign sel[i] = (code != '0) && (CODE_W'(i) <= code);
      end
   endgenerate

   // All selected keys pressed (low); unselected keys are don't-care
   logic all_low;
   assign all_low = (sel != '0) && ((keys_s_n & sel) == '0);

   generate
      if (HOLD_CYCLES == 1) begin : g_direct
         assign fire = all_low && !block;
      end else begin : g_count
         logic [HOLD_W-1:0] hold_cnt;

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                    hold_cnt <= '0;
            else if (!all_low || block)    hold_cnt <= '0;
            else if (hold_cnt != HOLD_LAST) hold_cnt <= hold_cnt + 1'b1;
         end

         assign fire = all_low && !block && (hold_cnt == HOLD_LAST);
      end
   endgenerate

endmodule

// File: rtl/kbd_combo_rst_pulse.sv
module kbd_combo_rst_pulse #(
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic start,
   output logic busy,
   output logic pulse
);

   import kbd_combo_rst_pkg::*;

   localparam int unsigned PW = cnt_width(PULSE_CYCLES);
   localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES);

   initial begin
      if (PULSE_CYCLES < 1) $error("kbd_combo_rst_pulse: PULSE_CYCLES must be at least 1");
   end

   pls_state_e    state;
   logic [PW-1:0] remain;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state  <= PLS_IDLE;
         remain <= '0;
      end else begin
         unique case (state)
            PLS_IDLE: begin
               if (start) begin
                  state  <= PLS_ACTIVE;
                  remain <= PLOAD;
               end
            end
            PLS_ACTIVE: begin
               if (remain == PW'(1)) begin
                  state  <= PLS_IDLE;
                  remain <= '0;
               end else begin
                  remain <= remain - 1'b1;
               end
            end
            default: state <= PLS_IDLE;
         endcase
      end
   end

   assign pulse = (state == PLS_ACTIVE);
   assign busy  = (state == PLS_ACTIVE);

endmodule

// File: rtl/kbd_combo_rst.sv
module kbd_combo_rst #(
   parameter int unsigned NUM_KEYS     = 4,
   parameter int unsigned CODE_W       = 2,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned HOLD_CYCLES  = 1024,
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                cfg_we,
   input  logic [CODE_W-1:0]   cfg_wdata,
   input  logic [NUM_KEYS-1:0] key_n,
   output logic                rst_req
);

   initial begin
      if (NUM_KEYS != (1 << CODE_W)) $error("kbd_combo_rst: NUM_KEYS must equal 2**CODE_W");
      if (SYNC_STAGES < 2)           $error("kbd_combo_rst: SYNC_STAGES must be at least 2");
   end

   logic [NUM_KEYS-1:0] key_s;
   logic [CODE_W-1:0]   cfg_q;
   logic                fire;
   logic                busy;

   kbd_combo_rst_sync #(
      .WIDTH  (NUM_KEYS),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .por_n (por_n),
      .din   (key_n),
      .dout  (key_s)
   );

   kbd_combo_rst_cfg #(
      .CODE_W (CODE_W)
   ) cfg_i (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .clr     (fire),
      .code    (cfg_q)
   );

   kbd_combo_rst_detect #(
      .NUM_KEYS    (NUM_KEYS),
      .CODE_W      (CODE_W),
      .HOLD_CYCLES (HOLD_CYCLES)
   ) det_i (
      .clk      (clk),
      .por_n    (por_n),
      .code     (cfg_q),
      .keys_s_n (key_s),
      .block    (busy),
      .fire     (fire)
   );

   kbd_combo_rst_pulse #(
      .PULSE_CYCLES (PULSE_CYCLES)
   ) pls_i (
      .clk   (clk),
      .por_n (por_n),
      .start (fire),
      .busy  (busy),
      .pulse (rst_req)
   );

endmodule

// File: rtl/kbd_combo_rst_chk.sv
module kbd_combo_rst_chk #(
   parameter int unsigned NUM_KEYS     = 4,
   parameter int unsigned CODE_W       = 2,
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic [CODE_W-1:0]   cfg_q,
   input  logic [NUM_KEYS-1:0] key_s,
   input  logic                rst_req
);

   logic [31:0] hi_cnt;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       hi_cnt <= '0;
      else if (rst_req) hi_cnt <= hi_cnt + 1;
      else              hi_cnt <= '0;
   end

   // Mask rebuilt from the code independently of the detector
   function automatic logic [NUM_KEYS-1:0] grp(input logic [CODE_W-1:0] c);
      logic [NUM_KEYS-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_KEYS; k++)
         if (c != '0 && k <= int'(c)) m[k] = 1'b1;
      return m;
   endfunction

   // R1 R2 R3
   req_needs_group_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req) |-> ((($past(key_s) & grp($past(cfg_q))) == '0) && ($past(cfg_q) != '0)));

   // R8
   cfg_cleared_on_req_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req) |-> (cfg_q == '0));

   // R7
   pulse_not_long_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |-> (hi_cnt < PULSE_CYCLES));

   // R7
   pulse_full_width_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req) |-> (hi_cnt == PULSE_CYCLES));

   // R4
   disabled_no_req_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_req && cfg_q == '0) |=> !rst_req);

endmodule

bind kbd_combo_rst kbd_combo_rst_chk #(
   .NUM_KEYS     (NUM_KEYS),
   .CODE_W       (CODE_W),
   .PULSE_CYCLES (PULSE_CYCLES)
) chk_i (
   .clk     (clk),
   .por_n   (por_n),
   .cfg_q   (cfg_q),
   .key_s   (key_s),
   .rst_req (rst_req)
);

// File: tb/kbd_combo_rst_tb.sv
module kbd_combo_rst_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD  = 4;
   localparam int PULSE = 3;
   localparam int RISE  = HOLD + 2;
   localparam int WIN   = 30;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_wdata = '0;
   logic [3:0] key_n = 4'hF;
   logic       rst_req;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kbd_combo_rst #(
      .NUM_KEYS     (4),
      .CODE_W       (2),
      .SYNC_STAGES  (2),
      .HOLD_CYCLES  (HOLD),
      .PULSE_CYCLES (PULSE)
   ) dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .key_n     (key_n),
      .rst_req   (rst_req)
   );

   // {tag[3:0], code[1:0], keys_n[3:0], len[5:0], expect_fire}
   localparam int NV = 12;
   localparam logic [16:0] VEC [NV] = '{
      {4'd1, 2'd3, 4'b0000, 6'd10, 1'b1},
      {4'd1, 2'd3, 4'b0001, 6'd10, 1'b0},
      {4'd1, 2'd3, 4'b1000, 6'd10, 1'b0},
      {4'd2, 2'd2, 4'b1000, 6'd10, 1'b1},
      {4'd2, 2'd2, 4'b0100, 6'd10, 1'b0},
      {4'd3, 2'd1, 4'b1100, 6'd10, 1'b1},
      {4'd3, 2'd1, 4'b0010, 6'd10, 1'b0},
      {4'd4, 2'd0, 4'b0000, 6'd10, 1'b0},
      {4'd5, 2'd3, 4'b0000, 6'd4,  1'b1},
      {4'd5, 2'd3, 4'b0000, 6'd3,  1'b0},
      {4'd3, 2'd1, 4'b0000, 6'd10, 1'b1},
      {4'd2, 2'd2, 4'b1011, 6'd10, 1'b0}
   };

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_por();
      @(negedge clk);
      por_n = 1'b0;
      key_n = 4'hF;
      cfg_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [1:0] c);
      cfg_we = 1'b1;
      cfg_wdata = c;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Apply pattern for len edges; report first-high edge index and high count
   task automatic observe(input logic [3:0] pat, input int len,
                          output int rise_at, output int width, output int rises);
      logic prev;
      rise_at = 0; width = 0; rises = 0; prev = 1'b0;
      key_n = pat;
      for (int c = 1; c <= WIN; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (c == len) key_n = 4'hF;
         if (rst_req) begin
            width++;
            if (!prev) begin
               rises++;
               if (rise_at == 0) rise_at = c;
            end
         end
         prev = rst_req;
      end
   endtask

   initial begin
      int ra, w, rs;
      string tag;

      // R4: reset state
      #(CLK_PERIOD*2 + 1);
      check("R4 reset", int'(rst_req), 0);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         do_por();
         write_cfg(VEC[v][12:11]);
         observe(VEC[v][10:7], int'(VEC[v][6:1]), ra, w, rs);
         tag = $sformatf("R%0d vec%0d", VEC[v][16:13], v);
         if (VEC[v][0]) begin
            check({tag, " rise edge (R5)"}, ra, RISE);
            check({tag, " width (R7)"}, w, PULSE);
         end else begin
            check({tag, " no request"}, rs, 0);
         end
      end

      // R4: no write after power-on, all keys pressed
      do_por();
      observe(4'b0000, WIN, ra, w, rs);
      check("R4 default disabled", rs, 0);

      // R6: press 3, release 1, press 3 -> no request
      do_por();
      write_cfg(2'd3);
      key_n = 4'b0000;
      for (int c = 0; c < 3; c++) @(negedge clk);
      key_n = 4'hF;
      @(negedge clk);
      key_n = 4'b0000;
      for (int c = 0; c < 3; c++) @(negedge clk);
      key_n = 4'hF;
      observe(4'hF, WIN, ra, w, rs);
      check("R6 restart on release", rs, 0);

      // R8: held keys give a single request, then re-write re-arms
      do_por();
      write_cfg(2'd2);
      observe(4'b0000, WIN + 10, ra, w, rs);
      check("R8 single request while held", rs, 1);
      check("R8 first rise (R5)", ra, RISE);
      key_n = 4'b0000;
      for (int c = 0; c < 4; c++) @(negedge clk);
      write_cfg(2'd2);
      observe(4'b0000, WIN + 10, ra, w, rs);
      check("R8 re-armed request", rs, 1);
      check("R8 re-armed width (R7)", w, PULSE);
      key_n = 4'hF;

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule